// File: doc/BRIEF.md
# PRESENT-80 Lightweight Block Encryption Core

This core encrypts 64-bit blocks with the PRESENT lightweight cipher under an 80-bit key. Plaintext arrives as four 16-bit words on a narrow input port. The ciphertext leaves as four 16-bit words on a narrow output port, one word per cycle, each marked by a valid strobe. Inside, one full cipher round runs per clock: 31 rounds, then a closing key addition. The 4-bit substitution box is plain combinational logic.

A stored key is kept between blocks. It is replaced only when `key_load` is asserted, so a stream can run under one fixed key or take a new key before any block. Once a block's ciphertext has moved into the output serialiser, the input port accepts the next block. Its four words are therefore taken in while the previous ciphertext is still leaving. The first block completes 42 cycles after its first word. In continuous use, later blocks complete every 37 cycles.

Top module: `present80_enc`

## Requirements
- R1: After reset, `out_valid` and `out_data` are 0 and the input port accepts a block at once.
- R2: Each block is PRESENT-80 encryption. Round i (1 to 31) does three things in order: it XORs key bits 79..16 into the state, maps every nibble through the S-box C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (inputs 0 to F), and moves bit j to bit 16*j mod 63, with bit 63 staying in place. The key then rotates left by 61 bits, its top nibble passes through the S-box, and i is XORed into key bits 19..15. A last XOR with key bits 79..16 follows round 31. For example, all-zero plaintext and key give 5579C1387B228445.
- R3: A word is taken when `in_valid` is high and no block is in flight. The four words of a block arrive most-significant word first.
- R4: Ciphertext leaves as four words on four consecutive cycles, most-significant word first, each with `out_valid` high. `out_valid` is low in every other cycle.
- R5: If the fourth word of a block is taken in cycle c, its output words appear in cycles c+35 to c+38. With words in cycles 0 to 3, the last output word is in cycle 41, so the block takes 42 cycles.
- R6: The first word of the next block is accepted from cycle c+34 on. Back-to-back blocks therefore finish 37 cycles apart, with loading overlapping the previous output.
- R7: Words presented from cycle c+1 to c+33 are ignored, even if `in_start` is high.
- R8: `key_load` stores `key_in`. A block uses the key stored as of the cycle its fourth word is taken, including a load in that same cycle. The stored key persists across blocks.
- R9: A `key_load` while a block is in flight leaves that block's result unchanged and applies to the following blocks.
- R10: An accepted word with `in_start` high is word 0 of a new block. Any earlier partial words are dropped.
- R11: The words of a block need not arrive on consecutive cycles. Idle cycles between them are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| in_valid | input | 1 | Input word qualifier |
| in_start | input | 1 | Marks word 0 of a block |
| in_data | input | 16 | Plaintext word |
| key_load | input | 1 | Store `key_in` this cycle |
| key_in | input | 80 | New key |
| out_valid | output | 1 | Ciphertext word valid |
| out_data | output | 16 | Ciphertext word |

## Verification
The hardest condition to reach is the tight overlap. In that case the next block's first word arrives in exactly the first cycle it can be accepted, while the previous ciphertext is still streaming out. A key change or stray words also land during the locked window. The stimulus has a behavioural model of the acceptance window, so it drives blocks at the earliest legal cycle. It then fills the compute window with junk words, start flags and key loads. Word gaps and mid-block restarts cover the counting paths.

// File: rtl/present_pkg.sv
package present_pkg;
  localparam int BLOCK_BITS = 64;
  localparam int KEY_BITS   = 80;
  localparam int PORT_BITS  = 16;
  localparam int NUM_ROUNDS = 31;
  localparam int RCON_BITS  = 5;
  localparam int RCON_LSB   = 15;
  localparam int KEY_ROT    = 61;
endpackage

// File: rtl/present_sbox4.sv
module present_sbox4 (
  input  logic [3:0] nib_i,
  output logic [3:0] nib_o
);
  always_comb begin
    case (nib_i)
      4'h0: nib_o = 4'hC;
      4'h1: nib_o = 4'h5;
      4'h2: nib_o = 4'h6;
      4'h3: nib_o = 4'hB;
      4'h4: nib_o = 4'h9;
      4'h5: nib_o = 4'h0;
      4'h6: nib_o = 4'hA;
      4'h7: nib_o = 4'hD;
      4'h8: nib_o = 4'h3;
      4'h9: nib_o = 4'hE;
      4'hA: nib_o = 4'hF;
      4'hB: nib_o = 4'h8;
      4'hC: nib_o = 4'h4;
      4'hD: nib_o = 4'h7;
      4'hE: nib_o = 4'h1;
      default: nib_o = 4'h2;
    endcase
  end
endmodule

// File: rtl/present_round.sv
module present_round #(
  parameter int BLK_W = present_pkg::BLOCK_BITS
) (
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  output logic [BLK_W-1:0] state_o
);
  localparam int NIBS = BLK_W / 4;

  logic [BLK_W-1:0] mixed;
  logic [BLK_W-1:0] subbed;

  assign mixed = state_i ^ rkey_i;

  for (genvar g = 0; g < NIBS; g++) begin : g_sub
    present_sbox4 u_sb (
      .nib_i (mixed[4*g +: 4]),
      .nib_o (subbed[4*g +: 4])
    );
  end

  // Bit b moves to b*NIBS mod (BLK_W-1); the top bit keeps its place.
  for (genvar b = 0; b < BLK_W; b++) begin : g_perm
    localparam int DST = (b == BLK_W - 1) ? b : (b * NIBS) % (BLK_W - 1);
    assign state_o[DST] = subbed[b];
  end
endmodule

// File: rtl/present_keyupd.sv
module present_keyupd #(
  parameter int KEY_W  = present_pkg::KEY_BITS,
  parameter int RC_W   = present_pkg::RCON_BITS,
  parameter int RC_LSB = present_pkg::RCON_LSB,
  parameter int ROT    = present_pkg::KEY_ROT
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [RC_W-1:0]  rc_i,
  output logic [KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] rotated;
  logic [3:0]       top_sub;

  assign rotated = {key_i[KEY_W-1-ROT:0], key_i[KEY_W-1:KEY_W-ROT]};

  present_sbox4 u_ksb (
    .nib_i (rotated[KEY_W-1 -: 4]),
    .nib_o (top_sub)
  );

  always_comb begin
    key_o                  = rotated;
    key_o[KEY_W-1 -: 4]    = top_sub;
    key_o[RC_LSB +: RC_W]  = rotated[RC_LSB +: RC_W] ^ rc_i;
  end
endmodule

// File: rtl/present_outser.sv
module present_outser #(
  parameter int BLK_W  = present_pkg::BLOCK_BITS,
  parameter int WORD_W = present_pkg::PORT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int NWORDS = BLK_W / WORD_W;
  localparam int CNT_W  = $clog2(NWORDS + 1);

  logic [BLK_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] dat_q, dat_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    vld_d = 1'b0;
    dat_d = dat_q;
    if (cnt_q != '0) begin
      vld_d = 1'b1;
      dat_d = sh_q[BLK_W-1 -: WORD_W];
      sh_d  = sh_q << WORD_W;
      cnt_d = cnt_q - 1'b1;
    end
    if (load_i) begin
      sh_d  = blk_i;
      cnt_d = CNT_W'(NWORDS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

  // R4: a burst keeps going while words remain
  a_r4_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && cnt_q != '0) |=> vld_q);

  // R5: the first word appears two edges after the handoff
  a_r5_first_word_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> $past(load_i, 2));
endmodule

// File: rtl/present80_enc.sv
module present80_enc #(
  parameter int BLK_W  = present_pkg::BLOCK_BITS,
  parameter int KEY_W  = present_pkg::KEY_BITS,
  parameter int WORD_W = present_pkg::PORT_BITS,
  parameter int ROUNDS = present_pkg::NUM_ROUNDS,
  parameter int RC_W   = present_pkg::RCON_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [WORD_W-1:0] in_data,
  input  logic              key_load,
  input  logic [KEY_W-1:0]  key_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  localparam int NWORDS = BLK_W / WORD_W;
  localparam int IDX_W  = $clog2(NWORDS);
  localparam int BUF_W  = BLK_W - WORD_W;
  localparam int RND_W  = $clog2(ROUNDS + 2);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NWORDS - 1);
  localparam logic [RND_W-1:0] LAST_RND  = RND_W'(ROUNDS);
  localparam logic [RND_W-1:0] FINAL_RND = RND_W'(ROUNDS + 1);

  // port side
  logic              accept, last_word;
  logic [IDX_W-1:0]  widx;
  logic [IDX_W-1:0]  pcnt_q, pcnt_d;
  logic              lock_q, lock_d;
  logic [KEY_W-1:0]  kstore_q, kstore_d;
  // registered input stage
  logic              inq_v_q, inq_last_q;
  logic [WORD_W-1:0] inq_dat_q, inq_dat_d;
  logic [BUF_W-1:0]  buf_q, buf_d;
  // datapath
  logic              start_blk, round_en, done;
  logic [BLK_W-1:0]  state_q, state_d, round_out, cipher;
  logic [KEY_W-1:0]  wkey_q, wkey_d, key_next;
  logic              run_q, run_d;
  logic [RND_W-1:0]  rnd_q, rnd_d;

  // ---------------- input acceptance ----------------
  always_comb begin
    accept    = in_valid && !lock_q;
    widx      = in_start ? '0 : pcnt_q;
    last_word = accept && (widx == LAST_IDX);
    pcnt_d    = accept ? IDX_W'(widx + 1'b1) : pcnt_q;
    kstore_d  = key_load ? key_in : kstore_q;
    inq_dat_d = accept ? in_data : inq_dat_q;
    if (last_word)  lock_d = 1'b1;
    else if (done)  lock_d = 1'b0;
    else            lock_d = lock_q;
  end

  // ---------------- word assembly ----------------
  always_comb begin
    buf_d     = inq_v_q ? {buf_q[BUF_W-WORD_W-1:0], inq_dat_q} : buf_q;
    start_blk = inq_v_q && inq_last_q;
  end

  // ---------------- round engine ----------------
  present_round #(.BLK_W(BLK_W)) u_round (
    .state_i (state_q),
    .rkey_i  (wkey_q[KEY_W-1 -: BLK_W]),
    .state_o (round_out)
  );

  present_keyupd #(.KEY_W(KEY_W), .RC_W(RC_W)) u_kupd (
    .key_i (wkey_q),
    .rc_i  (rnd_q[RC_W-1:0]),
    .key_o (key_next)
  );

  always_comb begin
    round_en = run_q && (rnd_q <= LAST_RND);
    done     = run_q && (rnd_q == FINAL_RND);
    cipher   = state_q ^ wkey_q[KEY_W-1 -: BLK_W];

    state_d = state_q;
    if (start_blk)     state_d = {buf_q, inq_dat_q};
    else if (round_en) state_d = round_out;

    wkey_d = wkey_q;
    if (last_word)     wkey_d = key_load ? key_in : kstore_q;
    else if (round_en) wkey_d = key_next;

    run_d = run_q;
    rnd_d = rnd_q;
    if (start_blk) begin
      run_d = 1'b1;
      rnd_d = RND_W'(1);
    end else if (round_en) begin
      rnd_d = rnd_q + 1'b1;
    end else if (done) begin
      run_d = 1'b0;
      rnd_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q     <= '0;
      lock_q     <= 1'b0;
      kstore_q   <= '0;
      inq_v_q    <= 1'b0;
      inq_last_q <= 1'b0;
      inq_dat_q  <= '0;
      buf_q      <= '0;
      state_q    <= '0;
      wkey_q     <= '0;
      run_q      <= 1'b0;
      rnd_q      <= '0;
    end else begin
      pcnt_q     <= pcnt_d;
      lock_q     <= lock_d;
      kstore_q   <= kstore_d;
      inq_v_q    <= accept;
      inq_last_q <= last_word;
      inq_dat_q  <= inq_dat_d;
      buf_q      <= buf_d;
      state_q    <= state_d;
      wkey_q     <= wkey_d;
      run_q      <= run_d;
      rnd_q      <= rnd_d;
    end
  end

  // ---------------- output serialiser ----------------
  present_outser #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (done),
    .blk_i   (cipher),
    .valid_o (out_valid),
    .data_o  (out_data)
  );

  // R7: the round engine only runs while the port is locked
  a_r7_lock_covers_run: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> lock_q);

  // R3: the lock engages only after a valid word at the port
  a_r3_lock_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(in_valid));

  // R2: every block starts at round one, from the registered last word
  a_r2_round_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (rnd_q == RND_W'(1)) && $past(inq_last_q));

  // R6: the port unlocks the cycle after the ciphertext handoff
  a_r6_unlock_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> !run_q && $past(run_q));
endmodule

// File: tb/present80_enc_tb_top.sv
`timescale 1ns/1ps
module present80_enc_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid, in_start, key_load;
  logic [15:0] in_data;
  logic [79:0] key_in;
  logic        out_valid;
  logic [15:0] out_data;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  bit mon_en   = 0;
  bit finished = 0;

  // behavioural model state
  logic [79:0] m_key;
  logic [63:0] m_buf;
  int          m_idx;
  int          free_cyc;
  int          exp_cyc[$];
  logic [15:0] exp_word[$];
  string       exp_tag[$];

  localparam logic [79:0] K0 = 80'h0;
  localparam logic [79:0] K1 = 80'hFFFF_FFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] P0 = 64'h0;
  localparam logic [63:0] P1 = 64'hFFFF_FFFF_FFFF_FFFF;

  present80_enc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .key_load(key_load), .key_in(key_in),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] sb(input logic [3:0] x);
    logic [3:0] t [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                           4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
    return t[x];
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] pt, input logic [79:0] key);
    logic [63:0] s, t, p;
    logic [79:0] k;
    s = pt;
    k = key;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ k[79:16];
      for (int n = 0; n < 16; n++) t[4*n +: 4] = sb(s[4*n +: 4]);
      for (int i = 0; i < 64; i++) p[(i == 63) ? 63 : (i * 16) % 63] = t[i];
      s = p;
      k = {k[18:0], k[79:19]};
      k[79:76] = sb(k[79:76]);
      k[19:15] = k[19:15] ^ 5'(r);
    end
    return s ^ k[79:16];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one input cycle: drive at a negedge, update model, wait next negedge
  task automatic tick(input bit v, input bit st, input logic [15:0] d,
                      input bit kl, input logic [79:0] k, input string tag);
    int          widx;
    logic [79:0] bkey;
    logic [63:0] ct;
    in_valid = v; in_start = st; in_data = d; key_load = kl; key_in = k;
    widx = st ? 0 : m_idx;
    bkey = kl ? k : m_key;
    if (v && cyc >= free_cyc) begin
      m_buf = {m_buf[47:0], d};
      if (widx == 3) begin
        ct = ref_enc(m_buf, bkey);
        for (int w = 0; w < 4; w++) begin
          exp_cyc.push_back(cyc + 35 + w);
          exp_word.push_back(ct[63 - 16*w -: 16]);
          exp_tag.push_back(tag);
        end
        free_cyc = cyc + 34;
        m_idx = 0;
      end else begin
        m_idx = widx + 1;
      end
    end
    if (kl) m_key = k;
    @(negedge clk);
  endtask

  task automatic idle_until(input int c);
    while (cyc < c) tick(0, 0, 16'h0, 0, K0, "");
  endtask

  task automatic send_block(input logic [63:0] pt, input bit kl,
                            input logic [79:0] k, input string tag);
    idle_until(free_cyc);
    for (int w = 0; w < 4; w++)
      tick(1, w == 0, pt[63 - 16*w -: 16], kl && w == 0, k, tag);
  endtask

  // compare the output port against the model every cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        checks++;
        if (!out_valid || out_data !== exp_word[0]) begin
          failures++;
          $display("FAIL %s cyc=%0d actual=%b/%h expected=1/%h",
                   exp_tag[0], cyc, out_valid, out_data, exp_word[0]);
        end
        void'(exp_cyc.pop_front());
        void'(exp_word.pop_front());
        void'(exp_tag.pop_front());
      end else if (out_valid) begin
        checks++;
        failures++;
        $display("FAIL R4 cyc=%0d actual=valid/%h expected=idle", cyc, out_data);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    in_valid = 0; in_start = 0; in_data = 0; key_load = 0; key_in = '0;
    m_key = '0; m_buf = '0; m_idx = 0; free_cyc = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 out_valid", 64'(out_valid), 64'h0);
    check("R1 out_data", 64'(out_data), 64'h0);

    // R2: reference model against published vectors
    check("R2 model p0k0", ref_enc(P0, K0), 64'h5579C1387B228445);
    check("R2 model p0k1", ref_enc(P0, K1), 64'hE72C46C0F5945049);
    check("R2 model p1k0", ref_enc(P1, K0), 64'hA112FFC72F68417B);
    check("R2 model p1k1", ref_enc(P1, K1), 64'h3333DCD3213210D2);

    free_cyc = cyc;
    mon_en = 1;

    // R2 R3 R4 R5 R8: single blocks with explicit key loads
    send_block(P0, 1, K0, "R2_R5_p0k0");
    send_block(P0, 1, K1, "R2_R8_p0k1");
    send_block(P1, 1, K0, "R2_R3_p1k0");
    send_block(P1, 1, K1, "R2_R4_p1k1");

    // R6 R8: back-to-back under a fixed key, earliest legal start
    send_block(64'h0123_4567_89AB_CDEF, 1, 80'h0123_4567_89AB_CDEF_0123, "R6_b2b0");
    send_block(64'hFEDC_BA98_7654_3210, 0, K0, "R6_b2b1");
    send_block(64'h5A5A_A5A5_3C3C_C3C3, 0, K0, "R6_R8_b2b2");

    // R7 R9: junk words, start flags and a key load while in flight
    send_block(64'h1111_2222_3333_4444, 0, K0, "R7_locked");
    while (cyc < free_cyc) begin
      if (cyc == free_cyc - 10)
        tick(1, 1, 16'hDEAD, 1, 80'hA5A5_5A5A_0F0F_F0F0_1234, "R9");
      else
        tick(1, cyc[0], 16'(cyc * 16'h3B1), 0, K0, "R7");
    end
    send_block(64'h1111_2222_3333_4444, 0, K0, "R9_newkey");

    // R10: a partial block abandoned by a new start
    idle_until(free_cyc + 3);
    tick(1, 1, 16'hAAAA, 0, K0, "R10");
    tick(1, 0, 16'hBBBB, 0, K0, "R10");
    send_block(64'hCAFE_F00D_1357_2468, 0, K0, "R10_resync");

    // R11 R8: gaps between words, key loaded with the last word
    idle_until(free_cyc + 2);
    tick(1, 1, 16'h9876, 0, K0, "R11");
    tick(0, 0, 16'h0, 0, K0, "R11");
    tick(1, 0, 16'h5432, 0, K0, "R11");
    tick(0, 0, 16'h0, 0, K0, "R11");
    tick(0, 0, 16'h0, 0, K0, "R11");
    tick(1, 0, 16'h10FE, 0, K0, "R11");
    tick(1, 0, 16'hDCBA, 1, K1, "R11_R8_gap");

    idle_until(free_cyc + 10);
    check("R4 drained", 64'(exp_cyc.size()), 64'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule